// File: doc/BRIEF.md
# Domain-Tagged DMA Translation Cache

This block keeps the final results of completed DMA address walks so that repeated device accesses to the same 4 KB page skip the walk. Each entry is tagged with the protection domain of the requesting device and with the DMA page number. It returns the physical page frame and separate read and write permission bits. A lookup is answered in the same cycle it is presented. On a miss the page walker runs and writes its result back through the fill port. The cache holds a small fixed number of entries, chosen for replacement in rotating order.

The cache stays consistent with the in-memory tables only when software tells it to. An invalidation request can clear every entry, only the entries of one domain, or only the entries of one domain whose pages fall inside an aligned block of two-to-the-power-order pages. The whole invalidation takes effect at one clock edge. The requester then sees a single-cycle completion pulse and may rely on the updated tables from that point. Only one invalidation is in flight at a time.

Top module: `dma_xlate_cache`

## Requirements
- R1: After reset no lookup hits and inv_done is low.
- R2: A lookup with lk_valid high hits in the same cycle exactly when a valid entry holds the same domain and the same page. A hit returns that entry's frame and read/write bits. A miss drives lk_frame, lk_rd and lk_wr to zero.
- R3: A fill is visible to lookups from the cycle after it is presented. A lookup in the fill cycle itself does not see it.
- R4: A fill whose domain and page already sit in a valid entry overwrites that entry's frame and permissions in place. It consumes no new slot and never leaves two entries with the same domain and page.
- R5: A fill of a new domain/page pair is written to the slot under a rotating pointer, which then steps to the next slot and wraps from the last slot to slot 0. With 8 slots, the ninth distinct fill evicts the first one.
- R6: inv_kind 2'b00 (global) removes every entry.
- R7: inv_kind 2'b01 (domain) removes only the entries whose domain equals inv_dom.
- R8: inv_kind 2'b10 (range) removes the entries of domain inv_dom whose page equals inv_page when the low inv_order bits of both are ignored. Entries of other domains and pages outside that block stay.
- R9: A lookup presented in the same cycle as an invalidation that covers the looked-up entry returns a miss. An uncovered entry still hits in that cycle.
- R10: A fill presented in the same cycle as an invalidation whose scope covers the fill's domain/page is discarded. A fill outside the scope is written normally.
- R11: inv_done is high for exactly one cycle, the cycle after the one in which inv_valid was accepted. The requester must not raise inv_valid while inv_done is high.
- R12: inv_kind 2'b11 removes no entry but still produces the inv_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_dom | input | DOM_W | Lookup domain identifier |
| lk_page | input | PAGE_W | Lookup DMA page number |
| lk_hit | output | 1 | Lookup hit (same cycle) |
| lk_frame | output | FRAME_W | Physical page frame on hit |
| lk_rd | output | 1 | Read permission on hit |
| lk_wr | output | 1 | Write permission on hit |
| fill_valid | input | 1 | Walker fill request |
| fill_dom | input | DOM_W | Fill domain identifier |
| fill_page | input | PAGE_W | Fill DMA page number |
| fill_frame | input | FRAME_W | Fill physical page frame |
| fill_rd | input | 1 | Fill read permission |
| fill_wr | input | 1 | Fill write permission |
| inv_valid | input | 1 | Invalidation request |
| inv_kind | input | 2 | 00 global, 01 domain, 10 page range, 11 no-op |
| inv_dom | input | DOM_W | Invalidation domain |
| inv_page | input | PAGE_W | Range base page |
| inv_order | input | ORDER_W | Range size as log2 of page count |
| inv_done | output | 1 | One-cycle completion pulse |

## Verification
Three functions can meet in one cycle: an invalidation with a lookup, and an invalidation with a fill. The bench provokes both. It presents a lookup or a fill in the very cycle an invalidation is issued, once with the target inside the scope and once outside it. A behavioural model then judges the same-cycle hit flag and the later visibility of the fill. A long random phase mixes all three requests over a small domain and page space. This repeats those collisions together with duplicate fills and wrap-around eviction.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    INV_ALL   = 2'b00,
    INV_DOM   = 2'b01,
    INV_RANGE = 2'b10,
    INV_NOP   = 2'b11
  } inv_kind_e;
endpackage

// File: rtl/xc_inv_scope.sv
module xc_inv_scope #(
  parameter int DOM_W   = 16,
  parameter int PAGE_W  = 20,
  parameter int ORDER_W = 5
) (
  input  logic               inv_valid,
  input  xc_pkg::inv_kind_e  inv_kind,
  input  logic [DOM_W-1:0]   inv_dom,
  input  logic [PAGE_W-1:0]  inv_page,
  input  logic [ORDER_W-1:0] inv_order,
  input  logic [DOM_W-1:0]   tag_dom,
  input  logic [PAGE_W-1:0]  tag_page,
  output logic               covered
);
  import xc_pkg::*;

  logic [PAGE_W-1:0] keep_mask;
  logic              dom_eq;
  logic              blk_eq;

  always_comb begin
    keep_mask = {PAGE_W{1'b1}} << inv_order;
    dom_eq    = (tag_dom == inv_dom);
    blk_eq    = ((tag_page & keep_mask) == (inv_page & keep_mask));
    covered   = 1'b0;
    if (inv_valid) begin
      unique case (inv_kind)
        INV_ALL:   covered = 1'b1;
        INV_DOM:   covered = dom_eq;
        INV_RANGE: covered = dom_eq & blk_eq;
        default:   covered = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/xc_rr_ptr.sv
module xc_rr_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R5: wrap from the last slot back to slot 0
  p_rr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr_q == LAST) |=> (ptr_q == '0));
  // R5: pointer holds when no new slot is taken
  p_rr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));
endmodule

// File: rtl/xc_onehot_mux.sv
module xc_onehot_mux #(
  parameter int N = 8,
  parameter int W = 26
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] data,
  output logic [W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < N; k++) begin
      dout = dout | (data[k] & {W{sel[k]}});
    end
  end
endmodule

// File: rtl/dma_xlate_cache.sv
module dma_xlate_cache #(
  parameter int ENTRIES = 8,
  parameter int DOM_W   = 16,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 24,
  parameter int ORDER_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [DOM_W-1:0]   lk_dom,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_rd,
  output logic               lk_wr,
  input  logic               fill_valid,
  input  logic [DOM_W-1:0]   fill_dom,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_rd,
  input  logic               fill_wr,
  input  logic               inv_valid,
  input  logic [1:0]         inv_kind,
  input  logic [DOM_W-1:0]   inv_dom,
  input  logic [PAGE_W-1:0]  inv_page,
  input  logic [ORDER_W-1:0] inv_order,
  output logic               inv_done
);
  import xc_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PAY_W = FRAME_W + 2;

  inv_kind_e kind;
  assign kind = inv_kind_e'(inv_kind);

  // entry storage
  logic [ENTRIES-1:0]              vld_q, vld_d;
  logic [ENTRIES-1:0][DOM_W-1:0]   dom_q;
  logic [ENTRIES-1:0][PAGE_W-1:0]  page_q;
  logic [ENTRIES-1:0][PAY_W-1:0]   pay_q;
  logic                            done_q;

  // per-slot compare results
  logic [ENTRIES-1:0] lk_match, fl_match, inv_cov, hit_vec, wr_sel;
  logic               fill_cov, fill_take, fill_dup, ptr_adv;
  logic [IDX_W-1:0]   victim;
  logic [PAY_W-1:0]   hit_pay;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign lk_match[i] = vld_q[i] & lk_valid &
                         (dom_q[i] == lk_dom) & (page_q[i] == lk_page);
    assign fl_match[i] = vld_q[i] &
                         (dom_q[i] == fill_dom) & (page_q[i] == fill_page);

    xc_inv_scope #(.DOM_W(DOM_W), .PAGE_W(PAGE_W), .ORDER_W(ORDER_W)) u_scope (
      .inv_valid (inv_valid),
      .inv_kind  (kind),
      .inv_dom   (inv_dom),
      .inv_page  (inv_page),
      .inv_order (inv_order),
      .tag_dom   (dom_q[i]),
      .tag_page  (page_q[i]),
      .covered   (inv_cov[i])
    );

    assign wr_sel[i] = fill_take & (fill_dup ? fl_match[i] : (victim == IDX_W'(i)));
  end

  xc_inv_scope #(.DOM_W(DOM_W), .PAGE_W(PAGE_W), .ORDER_W(ORDER_W)) u_fill_scope (
    .inv_valid (inv_valid),
    .inv_kind  (kind),
    .inv_dom   (inv_dom),
    .inv_page  (inv_page),
    .inv_order (inv_order),
    .tag_dom   (fill_dom),
    .tag_page  (fill_page),
    .covered   (fill_cov)
  );

  assign fill_take = fill_valid & ~fill_cov;
  assign fill_dup  = |fl_match;
  assign ptr_adv   = fill_take & ~fill_dup;

  xc_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ptr_adv),
    .ptr   (victim)
  );

  // lookup path: an entry being removed this cycle no longer hits
  assign hit_vec = lk_match & ~inv_cov;
  assign lk_hit  = |hit_vec;

  xc_onehot_mux #(.N(ENTRIES), .W(PAY_W)) u_hit_mux (
    .sel  (hit_vec),
    .data (pay_q),
    .dout (hit_pay)
  );

  assign lk_frame = hit_pay[PAY_W-1:2];
  assign lk_rd    = hit_pay[1];
  assign lk_wr    = hit_pay[0];

  // next state of valid bits
  always_comb begin
    vld_d = (vld_q & ~inv_cov) | wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      done_q <= inv_valid;
    end
  end

  for (genvar j = 0; j < ENTRIES; j++) begin : g_data
    always_ff @(posedge clk) begin
      if (wr_sel[j]) begin
        dom_q[j]  <= fill_dom;
        page_q[j] <= fill_page;
        pay_q[j]  <= {fill_frame, fill_rd, fill_wr};
      end
    end
  end

  assign inv_done = done_q;

  // R4: no two valid entries ever match one lookup
  p_unique_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R6: a global invalidation leaves nothing valid
  p_global_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_kind == 2'b00) |=> (vld_q == '0));
  // R9: lookup colliding with a global invalidation misses
  p_kill_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && inv_valid && inv_kind == 2'b00) |-> !lk_hit);
  // R11: completion follows an accepted request
  p_done_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> inv_done);
  // R11: one invalidation outstanding at a time
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> !inv_valid);
  // R2: a miss drives zeros on the payload
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_frame == '0 && !lk_rd && !lk_wr));
endmodule

// File: tb/dma_xlate_cache_bench.sv
module dma_xlate_cache_bench;
  localparam int CLK_P   = 10;
  localparam int NENT    = 8;
  localparam int DOM_W   = 16;
  localparam int PAGE_W  = 20;
  localparam int FRAME_W = 24;
  localparam int ORDER_W = 5;

  logic clk, rst_n;
  logic lk_valid, lk_hit, lk_rd, lk_wr;
  logic [DOM_W-1:0] lk_dom, fill_dom, inv_dom;
  logic [PAGE_W-1:0] lk_page, fill_page, inv_page;
  logic [FRAME_W-1:0] lk_frame, fill_frame;
  logic fill_valid, fill_rd, fill_wr, inv_valid, inv_done;
  logic [1:0] inv_kind;
  logic [ORDER_W-1:0] inv_order;

  dma_xlate_cache #(.ENTRIES(NENT), .DOM_W(DOM_W), .PAGE_W(PAGE_W),
                    .FRAME_W(FRAME_W), .ORDER_W(ORDER_W)) u_dma_xlate_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_dom(lk_dom), .lk_page(lk_page),
    .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_rd(lk_rd), .lk_wr(lk_wr),
    .fill_valid(fill_valid), .fill_dom(fill_dom), .fill_page(fill_page),
    .fill_frame(fill_frame), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_dom(inv_dom),
    .inv_page(inv_page), .inv_order(inv_order), .inv_done(inv_done)
  );

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural model: list of cached translations
  bit m_vld [NENT];
  int m_dom [NENT];
  int m_page [NENT];
  int m_frame [NENT];
  bit m_rd [NENT];
  bit m_wr [NENT];
  int m_next = 0;
  bit m_done = 0;

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  function automatic bit covers(int k, int d, int p, int o, int ed, int ep);
    case (k)
      0: return 1;
      1: return ed == d;
      2: return (ed == d) && ((ep >> o) == (p >> o));
      default: return 0;
    endcase
  endfunction

  function automatic bit inv_hits(int ed, int ep);
    return inv_valid && covers(int'(inv_kind), int'(inv_dom), int'(inv_page),
                               int'(inv_order), ed, ep);
  endfunction

  // model update at each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_vld[k]) m_vld[k] = 0;
      m_next = 0;
      m_done = 0;
    end else begin
      int slot;
      bit take;
      slot = -1;
      take = fill_valid && !inv_hits(int'(fill_dom), int'(fill_page));
      for (int k = 0; k < NENT; k++)
        if (m_vld[k] && m_dom[k] == int'(fill_dom) && m_page[k] == int'(fill_page)) slot = k;
      for (int k = 0; k < NENT; k++)
        if (m_vld[k] && inv_hits(m_dom[k], m_page[k])) m_vld[k] = 0;
      if (take) begin
        if (slot < 0) begin
          slot = m_next;
          m_next = (m_next + 1) % NENT;
        end
        m_vld[slot] = 1; m_dom[slot] = int'(fill_dom); m_page[slot] = int'(fill_page);
        m_frame[slot] = int'(fill_frame); m_rd[slot] = fill_rd; m_wr[slot] = fill_wr;
      end
      m_done = inv_valid;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare against the model away from the edge
  always @(negedge clk) begin
    if (running && rst_n) begin
      bit eh;
      int ef, er, ew;
      eh = 0; ef = 0; er = 0; ew = 0;
      if (lk_valid)
        for (int k = 0; k < NENT; k++)
          if (m_vld[k] && m_dom[k] == int'(lk_dom) && m_page[k] == int'(lk_page)
              && !inv_hits(m_dom[k], m_page[k])) begin
            eh = 1; ef = m_frame[k]; er = int'(m_rd[k]); ew = int'(m_wr[k]);
          end
      check("hit", int'(lk_hit), int'(eh));
      check("frame", int'(lk_frame), ef);
      check("perm", int'({lk_rd, lk_wr}), (er << 1) | ew);
      check("done", int'(inv_done), int'(m_done));
    end
  end

  task automatic clr();
    lk_valid = 0; fill_valid = 0; inv_valid = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr();
  endtask

  task automatic look(int d, int p);
    lk_valid = 1; lk_dom = DOM_W'(d); lk_page = PAGE_W'(p);
  endtask

  task automatic fill(int d, int p, int f, bit r, bit w);
    fill_valid = 1; fill_dom = DOM_W'(d); fill_page = PAGE_W'(p);
    fill_frame = FRAME_W'(f); fill_rd = r; fill_wr = w;
  endtask

  task automatic inval(int k, int d, int p, int o);
    inv_valid = 1; inv_kind = 2'(k); inv_dom = DOM_W'(d);
    inv_page = PAGE_W'(p); inv_order = ORDER_W'(o);
  endtask

  task automatic look_tick(int d, int p);
    look(d, p); tick();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    lk_dom = '0; lk_page = '0; fill_dom = '0; fill_page = '0; fill_frame = '0;
    fill_rd = 0; fill_wr = 0; inv_kind = '0; inv_dom = '0; inv_page = '0; inv_order = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    running = 1;

    tag = "R1";
    look_tick(0, 0); look_tick(1, 'h100); look_tick(7, 'hfffff);

    tag = "R3";
    fill(1, 'h100, 'haaaaa, 1, 0); look(1, 'h100); tick();
    tag = "R2";
    look_tick(1, 'h100); look_tick(2, 'h100); look_tick(1, 'h101);

    tag = "R4";
    fill(1, 'h100, 'hbbbbb, 1, 1); tick();
    look_tick(1, 'h100);

    tag = "R5";
    for (int n = 0; n < 7; n++) begin fill(1, 'h200 + n, 'h1000 + n, n[0], 1); tick(); end
    look_tick(1, 'h100);
    fill(1, 'h300, 'h3000, 0, 1); tick();
    look_tick(1, 'h100); look_tick(1, 'h300); look_tick(1, 'h206);

    tag = "R8";
    fill(3, 'h410, 'h410, 1, 1); tick();
    fill(3, 'h411, 'h411, 1, 0); tick();
    fill(3, 'h417, 'h417, 0, 1); tick();
    fill(3, 'h418, 'h418, 1, 1); tick();
    fill(4, 'h412, 'h412, 1, 1); tick();
    inval(2, 3, 'h410, 3); tick();
    look_tick(3, 'h410); look_tick(3, 'h411); look_tick(3, 'h417);
    look_tick(3, 'h418); look_tick(4, 'h412);

    tag = "R7";
    inval(1, 4, 0, 0); tick();
    look_tick(4, 'h412); look_tick(3, 'h418);

    tag = "R9";
    look(3, 'h418); inval(1, 3, 0, 0); tick();
    tick();
    look(1, 'h206); inval(2, 1, 'h300, 0); tick();
    look_tick(1, 'h300);

    tag = "R10";
    fill(5, 'h500, 'h5, 1, 1); inval(1, 5, 0, 0); tick();
    look_tick(5, 'h500);
    fill(6, 'h600, 'h6, 1, 0); inval(1, 5, 0, 0); tick();
    look_tick(6, 'h600);

    tag = "R12";
    inval(3, 6, 'h600, 0); tick();
    look_tick(6, 'h600); look_tick(1, 'h206);

    tag = "R6";
    inval(0, 0, 0, 0); tick();
    look_tick(6, 'h600); look_tick(1, 'h206); look_tick(1, 'h205);

    tag = "R11";
    begin
      bit last_inv;
      last_inv = 0;
      for (int n = 0; n < 3000; n++) begin
        int r;
        r = $urandom_range(0, 9);
        if (r < 5) look($urandom_range(0, 2), $urandom_range(0, 15));
        if (r >= 3 && r < 8) fill($urandom_range(0, 2), $urandom_range(0, 15),
                                  $urandom, $urandom_range(0, 1), $urandom_range(0, 1));
        if (!last_inv && $urandom_range(0, 7) == 0) begin
          inval($urandom_range(0, 3), $urandom_range(0, 2),
                $urandom_range(0, 15), $urandom_range(0, 3));
          last_inv = 1;
        end else last_inv = 0;
        tick();
      end
    end
    tick(); tick();

    running = 0;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule